// File: doc/BRIEF.md
# Triggered One-Pulse Compare Timer

This block is a single timer channel. An up-counter stays idle until a trigger input is sampled high. It then counts from zero to a programmable period. Each cycle, a comparator checks the count against a compare value. A mode controller turns the comparator result into a reference output that holds its state. It keeps that value until the selected mode tells it to change, including across changes of mode.

The counter runs in one of two ways:
- In one-pulse operation it makes a single pass, stops at zero and waits for the next trigger.
- Otherwise it wraps to zero and keeps counting.

The compare modes are frozen, set on match, clear on match and toggle on match. Two force modes drive the reference low or high at once. A typical use is a delayed edge. The channel is armed in set-on-match mode and started by a trigger. The edge is later cleared by a short visit to force-low. That visit leaves the channel waiting for the next compare match before the reference can rise again.

Top module: `oneshot_cmp_timer`

## Requirements
- R1: With `rst` high at a clock edge, `ref_o`, `match_o` and `running_o` are all low after that edge, and the count is zero.
- R2: While idle, the counter does not advance. A `trig_i` sampled high at edge E makes `running_o` high after E, with the count at 0. The trigger by itself never changes `ref_o`.
- R3: While running, the count advances by one per cycle from 0 to `period_i`. With `one_pulse_i` = 1, `running_o` is low after edge E+period+1 and the counter waits at zero. With `one_pulse_i` = 0, the count wraps to 0 and `running_o` stays high.
- R4: A compare match is a cycle in which the counter runs and the count equals `cmp_i`. `match_o` is high for exactly the one cycle after that match cycle, whatever the mode. After a trigger at edge E, the first match pulse follows edge E+cmp+1. With `cmp_i` > `period_i`, `match_o` never pulses.
- R5: In mode 1 (set on match), `ref_o` goes high on the edge ending a match cycle and stays high after the counter stops. In mode 2 (clear on match), `ref_o` goes low on that edge.
- R6: In mode 3 (toggle on match), `ref_o` inverts once for each match pulse and at no other time.
- R7: In mode 0 (frozen), and in the unused codes 6 and 7, `ref_o` holds its value through any number of matches.
- R8: Mode 4 (force low) drives `ref_o` low, and mode 5 (force high) drives it high, one edge after the mode is applied, whatever the counter or comparator is doing.
- R9: After leaving a force mode for mode 1, `ref_o` keeps its forced value until the next compare match.
- R10: A `trig_i` sampled high while `running_o` is high is ignored: the count is not restarted and the stop time of a one-pulse pass is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Start request, sampled each edge |
| mode_i | input | 3 | Compare mode: 0 frozen, 1 set, 2 clear, 3 toggle, 4 force low, 5 force high |
| cmp_i | input | CNT_W | Compare value |
| period_i | input | CNT_W | Last count value of a pass |
| one_pulse_i | input | 1 | 1: stop after one pass; 0: wrap and keep counting |
| ref_o | output | 1 | Latched reference output |
| match_o | output | 1 | One-cycle compare match pulse |
| running_o | output | 1 | Counter running status |

## Verification
All three outputs are registered. Each responds on the edge that samples its cause:
- `running_o` rises one edge after the trigger edge.
- `match_o` and the compare-driven change of `ref_o` both appear one edge after the cycle in which the count equals the compare value. Counted from the trigger edge, that is edge cmp+1.
- In one-pulse operation, `running_o` falls after edge period+1.
- A force mode shows on `ref_o` one edge after it is applied.

The bench drives inputs on the falling edge and samples outputs on the next falling edge. Each check therefore sees the state left by exactly one rising edge. The directed checks count edges from the trigger edge and compare them with these offsets. A per-cycle model in the bench tracks the same one-edge latency during the random phase.

// File: rtl/oneshot_cmp_timer.sv
`timescale 1ns/1ps
module oneshot_cmp_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             one_pulse_i,
  output logic             ref_o,
  output logic             match_o,
  output logic             running_o
);
  localparam logic [2:0] MD_SET = 3'd1;
  localparam logic [2:0] MD_CLR = 3'd2;
  localparam logic [2:0] MD_TOG = 3'd3;
  localparam logic [2:0] MD_LO  = 3'd4;
  localparam logic [2:0] MD_HI  = 3'd5;

  logic [CNT_W-1:0] cnt;
  logic             run, ref_q, hit_q;

  wire at_cmp = run && (cnt == cmp_i);
  wire at_end = run && (cnt == period_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      if (trig_i) run <= 1'b1;
    end else if (at_end) begin
      cnt <= '0;
      if (one_pulse_i) run <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= at_cmp;
      case (mode_i)
        MD_LO:   ref_q <= 1'b0;
        MD_HI:   ref_q <= 1'b1;
        MD_SET:  if (at_cmp) ref_q <= 1'b1;
        MD_CLR:  if (at_cmp) ref_q <= 1'b0;
        MD_TOG:  if (at_cmp) ref_q <= ~ref_q;
        default: ref_q <= ref_q;
      endcase
    end
  end

  assign ref_o     = ref_q;
  assign match_o   = hit_q;
  assign running_o = run;
endmodule

module oneshot_cmp_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             trig_i,
  input logic [2:0]       mode_i,
  input logic [CNT_W-1:0] cmp_i,
  input logic [CNT_W-1:0] period_i,
  input logic             ref_o,
  input logic             match_o,
  input logic             running_o
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!ref_o && !match_o && !running_o));
  // R2
  a_r2_idle_waits: assert property (@(posedge clk) disable iff (rst)
    (!running_o && !trig_i) |=> !running_o);
  a_r2_trigger_starts: assert property (@(posedge clk) disable iff (rst)
    (!running_o && trig_i) |=> running_o);
  // R4
  a_r4_no_match_idle: assert property (@(posedge clk) disable iff (rst)
    !running_o |=> !match_o);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (match_o && period_i != '0) |=> !match_o);
  // R5
  a_r5_set_holds: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd1 && ref_o) |=> ref_o);
  // R7
  a_r7_frozen_holds: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd0 || mode_i == 3'd6 || mode_i == 3'd7) |=> $stable(ref_o));
  // R8
  a_r8_force_low: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd4) |=> !ref_o);
  a_r8_force_high: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd5) |=> ref_o);
  // R9
  a_r9_no_change_without_match: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd1 && !running_o) |=> $stable(ref_o));
endmodule

bind oneshot_cmp_timer oneshot_cmp_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .trig_i(trig_i), .mode_i(mode_i), .cmp_i(cmp_i),
  .period_i(period_i), .ref_o(ref_o), .match_o(match_o), .running_o(running_o)
);

// File: tb/oneshot_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module oneshot_cmp_timer_tb_top;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst = 1'b1, trig = 1'b0, op = 1'b1;
  logic [2:0] mode = 3'd0;
  logic [W-1:0] cmp = '0, per = '0;
  logic ref_s, match_s, run_s;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  logic [W-1:0] m_cnt;
  logic m_run, m_ref, m_hit;

  always #2.5 clk = ~clk;

  oneshot_cmp_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .trig_i(trig), .mode_i(mode), .cmp_i(cmp),
    .period_i(per), .one_pulse_i(op), .ref_o(ref_s), .match_o(match_s),
    .running_o(run_s));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic next_ref(input logic [2:0] md, input logic cur, input logic hit);
    case (md)
      3'd4: return 1'b0;
      3'd5: return 1'b1;
      3'd1: return hit ? 1'b1 : cur;
      3'd2: return hit ? 1'b0 : cur;
      3'd3: return hit ? ~cur : cur;
      default: return cur;
    endcase
  endfunction

  task automatic tick();
    logic hit, fin;
    @(posedge clk);
    if (rst) begin
      m_cnt = '0; m_run = 1'b0; m_ref = 1'b0; m_hit = 1'b0;
    end else begin
      hit = m_run && (m_cnt == cmp);
      fin = m_run && (m_cnt == per);
      m_ref = next_ref(mode, m_ref, hit);
      m_hit = hit;
      if (!m_run) begin m_cnt = '0; m_run = trig; end
      else if (fin) begin m_cnt = '0; if (op) m_run = 1'b0; end
      else m_cnt = m_cnt + 1'b1;
    end
    @(negedge clk);
    chk("R5 model ref_o", ref_s, m_ref);
    chk("R4 model match_o", match_s, m_hit);
    chk("R3 model running_o", run_s, m_run);
  endtask

  task automatic do_reset();
    rst = 1'b1; trig = 1'b0;
    repeat (2) tick();
    rst = 1'b0;
  endtask

  // trigger on edge 0, report first match edge and stop edge
  task automatic pass(input int retrig_at, output int first_m, output int stop_at, output int ref_before);
    first_m = -1; stop_at = -1; ref_before = -1;
    trig = 1'b1; tick(); trig = 1'b0;
    for (int j = 1; j <= 40; j++) begin
      trig = (j == retrig_at);
      if (j == int'(cmp) + 1) ref_before = ref_s;
      tick();
      if (match_s && first_m < 0) first_m = j;
      if (!run_s && stop_at < 0) stop_at = j;
    end
    trig = 1'b0;
  endtask

  initial begin
    int fm, st, rb, nm, nflip;
    logic prev;
    m_cnt = '0; m_run = 1'b0; m_ref = 1'b0; m_hit = 1'b0;
    @(negedge clk);
    do_reset();
    chk("R1 ref after reset", ref_s, 0);
    chk("R1 match after reset", match_s, 0);
    chk("R1 running after reset", run_s, 0);

    repeat (4) tick();
    chk("R2 idle without trigger", run_s, 0);

    per = 10; cmp = 4; mode = 3'd1; op = 1'b1;
    trig = 1'b1; tick(); trig = 1'b0;
    chk("R2 running after trigger", run_s, 1);
    chk("R2 trigger leaves ref", ref_s, 0);
    do_reset();
    pass(0, fm, st, rb);
    chk("R4 first match edge", fm, 5);
    chk("R3 one-pulse stop edge", st, 11);
    chk("R5 set ref held after stop", ref_s, 1);

    mode = 3'd4; tick();
    chk("R8 force low", ref_s, 0);
    mode = 3'd1; repeat (5) tick();
    chk("R9 ref stays low after leaving force", ref_s, 0);
    pass(3, fm, st, rb);
    chk("R9 ref low until match", rb, 0);
    chk("R9 ref high after match", ref_s, 1);
    chk("R10 retrigger ignored, stop edge", st, 11);
    chk("R10 retrigger ignored, match edge", fm, 5);

    mode = 3'd2; pass(0, fm, st, rb);
    chk("R5 clear on match", ref_s, 0);

    cmp = 12; mode = 3'd1; pass(0, fm, st, rb);
    chk("R4 no match when cmp>period", fm, -1);
    chk("R4 ref unchanged without match", ref_s, 0);

    mode = 3'd5; tick();
    chk("R8 force high", ref_s, 1);
    mode = 3'd0; cmp = 2; per = 5;
    pass(0, fm, st, rb);
    chk("R7 frozen saw a match", int'(fm > 0), 1);
    chk("R7 frozen holds ref", ref_s, 1);
    mode = 3'd7; pass(0, fm, st, rb);
    chk("R7 unused code holds ref", ref_s, 1);

    mode = 3'd3; op = 1'b0; nm = 0; nflip = 0;
    trig = 1'b1; tick(); trig = 1'b0;
    prev = ref_s;
    for (int j = 0; j < 30; j++) begin
      tick();
      if (match_s) nm++;
      if (ref_s != prev) nflip++;
      prev = ref_s;
    end
    chk("R3 continuous keeps running", run_s, 1);
    chk("R6 toggle count equals matches", nflip, nm);
    chk("R6 matches in wrap mode", nm, 5);

    for (int i = 0; i < 4000; i++) begin
      rst  = ($urandom % 300) == 0;
      trig = ($urandom % 6) == 0;
      if (($urandom % 8) == 0) mode = 3'($urandom % 8);
      if (($urandom % 40) == 0) begin
        cmp = W'($urandom % 12); per = W'($urandom % 10); op = 1'($urandom);
      end
      tick();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1000000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule